// File: doc/BRIEF.md
# Receive FIFO DMA Drain Controller

This block sits between a small receive FIFO, which is filled by an input data port, and a memory write channel. While DMA is enabled it takes words from the head of the FIFO and writes them to consecutive memory addresses. It stops when a programmed word count has been used up, then pulses an end-of-transfer interrupt and latches it into a status bit. While DMA is disabled, software drains the FIFO itself through a read strobe. A fill-level interrupt tells software that the FIFO holds more words than a programmed 4-bit threshold.

DMA can be paused and later resumed in place. Pausing leaves the FIFO and the transfer position untouched. Software can also use the fill-level interrupt while a transfer is paused. The threshold interrupt stays quiet whenever DMA owns the FIFO. Dropping the port enable flushes the FIFO and abandons any outstanding transfer.

Top module: `rxd_drain_top`

## Requirements
- R1: The control register is at select 0. It holds the port enable at bit 7, the DMA enable at bit 5 and the fill threshold at bits [3:0]. Select 1 is the start address, select 2 is the word count and select 3 is the status register.
- R2: A control write moves DMA enable from 0 to 1 with the port enable set. If no transfer is outstanding and the count register is nonzero, the start address and count are loaded and `dma_busy_o` rises.
- R3: `mem_req_o` is high only while a transfer is outstanding, DMA is enabled and the FIFO is not empty. Each cycle with `mem_req_o` and `mem_rdy_i` both high moves one word in FIFO order. The first word goes to the start address and the address rises by one per word.
- R4: When the last counted word moves, `dma_busy_o` falls and `eot_irq_o` is high for exactly the next cycle. Status bit 0 (`eot_sts_o`) then reads 1.
- R5: While DMA enable is clear, no word moves to memory. The FIFO level and contents are changed only by input words and manual reads.
- R6: Setting DMA enable again with a transfer outstanding continues from the next address and the remaining count. Nothing is reloaded.
- R7: `thr_irq_o` is 1 exactly when the port is enabled, DMA is disabled and the FIFO level is strictly greater than the threshold.
- R8: While DMA enable is set, `thr_irq_o` stays 0.
- R9: While a transfer is outstanding, writes to the start address, the count and the threshold field are ignored. The two enable bits still take effect.
- R10: Clearing the port enable empties the FIFO and abandons any outstanding transfer without an end-of-transfer pulse. The next start uses the register values.
- R11: The FIFO holds 8 words. An input word is taken only while the port is enabled and the FIFO is not full. A word arriving while the FIFO is full is dropped and sets sticky status bit 1 (`ovf_sts_o`).
- R12: Writing 1 to a status bit at select 3 clears it. If a setting event occurs in the same cycle, the set wins.
- R13: With DMA disabled, `sw_rd_data_o` shows the FIFO head and `sw_rd_i` removes it. With DMA enabled, `sw_rd_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input port word strobe |
| in_data_i | input | DW | Input port word |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| sw_rd_i | input | 1 | Manual FIFO read strobe |
| sw_rd_data_o | output | DW | FIFO head for manual reads |
| mem_req_o | output | 1 | Memory write request |
| mem_rdy_i | input | 1 | Memory ready |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | DW | Memory write data |
| eot_irq_o | output | 1 | End-of-transfer pulse |
| thr_irq_o | output | 1 | Fill-threshold interrupt |
| eot_sts_o | output | 1 | Latched end-of-transfer status |
| ovf_sts_o | output | 1 | Sticky overflow status |
| dma_busy_o | output | 1 | Transfer outstanding |
| fifo_level_o | output | LW | FIFO word count |

## Verification
The bench pauses a transfer partway through and sends more words and register writes during the pause. A design that reloads on resume, or that accepts the address or count writes during the pause, puts words at the wrong addresses or ends with the wrong number of words. It also checks the threshold at the boundary where the level equals the threshold, and checks that the interrupt stays low while DMA is enabled. A comparison of the wrong strictness, or a missing suppression, shows up at once. The bench overfills the FIFO and aborts a transfer by dropping the port enable. A design that overwrites the stored words, or that pulses end-of-transfer on an abort, fails the data check or the interrupt count.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  localparam int CTRL_PORT_BIT = 7;
  localparam int CTRL_DMA_BIT  = 5;
  localparam int THR_W         = 4;
  localparam int STAT_EOT_BIT  = 0;
  localparam int STAT_OVF_BIT  = 1;
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign drop_o  = push_i & full_o & ~flush_i;
  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_q == '0));
  assert_full_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(level_q));
endmodule

// File: rtl/rxd_dma_eng.sv
module rxd_dma_eng #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          run_i,
  input  logic          abort_i,
  input  logic          avail_i,
  input  logic          rdy_i,
  output logic          req_o,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          eot_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          busy_q, eot_q;
  logic          last_word;

  assign req_o     = busy_q & run_i & avail_i;
  assign fire_o    = req_o & rdy_i;
  assign last_word = (rem_q == CW'(1));
  assign addr_o    = addr_q;
  assign busy_o    = busy_q;
  assign eot_o     = eot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      eot_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        addr_q <= base_i;
        rem_q  <= count_i;
        busy_q <= (count_i != '0);
      end else if (fire_o) begin
        addr_q <= addr_q + 1'b1;
        rem_q  <= rem_q - 1'b1;
        if (last_word) begin
          busy_q <= 1'b0;
          eot_q  <= 1'b1;
        end
      end
    end
  end

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !last_word && !abort_i) |=> (addr_q == $past(addr_q) + 1'b1));
  assert_pause_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !run_i && !start_i) |=> ($stable(addr_q) && $stable(rem_q)));
  assert_eot_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_q |=> !eot_q);
  assert_no_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/rxd_irq.sv
module rxd_irq #(
  parameter int LW    = 4,
  parameter int THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LW-1:0]    level_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             port_en_i,
  input  logic             dma_en_i,
  input  logic             eot_set_i,
  input  logic             ovf_set_i,
  input  logic             eot_clr_i,
  input  logic             ovf_clr_i,
  output logic             thr_irq_o,
  output logic             eot_sts_o,
  output logic             ovf_sts_o
);
  logic eot_q, ovf_q;

  assign thr_irq_o = port_en_i & ~dma_en_i & (32'(level_i) > 32'(thr_i));
  assign eot_sts_o = eot_q;
  assign ovf_sts_o = ovf_q;

  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eot_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (eot_set_i)      eot_q <= 1'b1;
      else if (eot_clr_i) eot_q <= 1'b0;
      if (ovf_set_i)      ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assert_w1c_eot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_clr_i && !eot_set_i) |=> !eot_q);
  assert_ovf_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/rxd_drain_top.sv
module rxd_drain_top #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          sw_rd_i,
  output logic [DW-1:0] sw_rd_data_o,
  output logic          mem_req_o,
  input  logic          mem_rdy_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          eot_irq_o,
  output logic          thr_irq_o,
  output logic          eot_sts_o,
  output logic          ovf_sts_o,
  output logic          dma_busy_o,
  output logic [LW-1:0] fifo_level_o
);
  import rxd_pkg::*;

  logic                port_en_q, dma_en_q;
  logic [THR_W-1:0]    thr_q;
  logic [AW-1:0]       base_q;
  logic [CW-1:0]       cnt_q;
  logic                wr_ctrl, wr_base, wr_cnt, wr_stat;
  logic                start, busy, fire, eot;
  logic                fifo_empty, fifo_full, fifo_drop, fifo_pop;
  logic [DW-1:0]       head;
  logic                cfg_unused;

  assign cfg_unused = ^cfg_wdata_i;
  assign wr_ctrl = cfg_we_i & (reg_sel_e'(cfg_sel_i) == SEL_CTRL);
  assign wr_base = cfg_we_i & (reg_sel_e'(cfg_sel_i) == SEL_BASE);
  assign wr_cnt  = cfg_we_i & (reg_sel_e'(cfg_sel_i) == SEL_COUNT);
  assign wr_stat = cfg_we_i & (reg_sel_e'(cfg_sel_i) == SEL_STAT);

  // fresh start only on a DMA-enable rise with nothing outstanding
  assign start = wr_ctrl & cfg_wdata_i[CTRL_DMA_BIT] & cfg_wdata_i[CTRL_PORT_BIT]
               & ~dma_en_q & ~busy & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_en_q <= 1'b0;
      dma_en_q  <= 1'b0;
      thr_q     <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        port_en_q <= cfg_wdata_i[CTRL_PORT_BIT];
        dma_en_q  <= cfg_wdata_i[CTRL_DMA_BIT];
        if (!busy) thr_q <= cfg_wdata_i[THR_W-1:0];
      end
      if (wr_base && !busy) base_q <= cfg_wdata_i[AW-1:0];
      if (wr_cnt && !busy)  cnt_q  <= cfg_wdata_i[CW-1:0];
    end
  end

  assign fifo_pop = fire | (sw_rd_i & ~dma_en_q & port_en_q);

  rxd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (~port_en_q),
    .push_i  (in_valid_i & port_en_q),
    .data_i  (in_data_i),
    .pop_i   (fifo_pop),
    .head_o  (head),
    .level_o (fifo_level_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .drop_o  (fifo_drop)
  );

  rxd_dma_eng #(.AW(AW), .CW(CW)) u_dma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .base_i  (base_q),
    .count_i (cnt_q),
    .run_i   (dma_en_q & port_en_q),
    .abort_i (~port_en_q),
    .avail_i (~fifo_empty),
    .rdy_i   (mem_rdy_i),
    .req_o   (mem_req_o),
    .fire_o  (fire),
    .addr_o  (mem_addr_o),
    .busy_o  (busy),
    .eot_o   (eot)
  );

  rxd_irq #(.LW(LW), .THR_W(THR_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (fifo_level_o),
    .thr_i     (thr_q),
    .port_en_i (port_en_q),
    .dma_en_i  (dma_en_q),
    .eot_set_i (eot),
    .ovf_set_i (fifo_drop),
    .eot_clr_i (wr_stat & cfg_wdata_i[STAT_EOT_BIT]),
    .ovf_clr_i (wr_stat & cfg_wdata_i[STAT_OVF_BIT]),
    .thr_irq_o (thr_irq_o),
    .eot_sts_o (eot_sts_o),
    .ovf_sts_o (ovf_sts_o)
  );

  assign sw_rd_data_o = head;
  assign mem_data_o   = head;
  assign eot_irq_o    = eot;
  assign dma_busy_o   = busy;

  assert_thr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_q |-> !thr_irq_o);
  assert_eot_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_irq_o |=> eot_sts_o);
  assert_req_has_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (fifo_level_o != '0));
  assert_abort_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_q |=> (!dma_busy_o && !eot_irq_o));
endmodule

// File: tb/sim_rxd_drain_top.sv
`timescale 1ns/1ps
module sim_rxd_drain_top;
  localparam int DW = 32, AW = 32, LW = 4;
  localparam logic [1:0] S_CTRL = 2'd0, S_BASE = 2'd1, S_CNT = 2'd2, S_STAT = 2'd3;
  localparam logic [31:0] PORT = 32'h80, DMA = 32'h20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, cfg_we_i = 1'b0, sw_rd_i = 1'b0, mem_rdy_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic [1:0] cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [DW-1:0] sw_rd_data_o, mem_data_o;
  logic [AW-1:0] mem_addr_o;
  logic mem_req_o, eot_irq_o, thr_irq_o, eot_sts_o, ovf_sts_o, dma_busy_o;
  logic [LW-1:0] fifo_level_o;

  int n_chk = 0, n_fail = 0, eot_cnt = 0;
  logic prev_eot = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] exp_addr = '0;

  always #2 clk_i = ~clk_i;

  rxd_drain_top u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of memory writes and end-of-transfer pulses
  always begin
    @(negedge clk_i); #1;
    if (rst_ni) begin
      if (mem_req_o && mem_rdy_i) begin
        if (exp_q.size() == 0) check("R3 unexpected write", 64'(mem_data_o), 64'hdead);
        else begin
          check("R3 data", 64'(mem_data_o), 64'(exp_q[0]));
          check("R3 addr", 64'(mem_addr_o), 64'(exp_addr));
          void'(exp_q.pop_front());
          exp_addr++;
        end
      end
      if (eot_irq_o) begin
        eot_cnt++;
        if (prev_eot) check("R4 pulse width", 64'd2, 64'd1);
      end
      prev_eot = eot_irq_o;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d, input bit keep);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = d;
    if (keep) exp_q.push_back(d);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic man_rd(input string tag);
    @(negedge clk_i); #1;
    check(tag, 64'(sw_rd_data_o), 64'(exp_q[0]));
    void'(exp_q.pop_front());
    sw_rd_i = 1'b1;
    @(negedge clk_i);
    sw_rd_i = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_i);
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && dma_busy_o; i++) @(negedge clk_i);
    settle();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 reset level", 64'(fifo_level_o), 0);
    check("R2 reset busy", 64'(dma_busy_o), 0);
    check("R3 reset req", 64'(mem_req_o), 0);
    check("R7 reset thr irq", 64'(thr_irq_o), 0);

    // manual mode, threshold boundary
    wr(S_CTRL, PORT | 32'd3);
    for (int i = 0; i < 5; i++) push(32'hA0 + i, 1);
    settle();
    check("R11 level after 5", 64'(fifo_level_o), 5);
    check("R7 level 5 > thr 3", 64'(thr_irq_o), 1);
    wr(S_CTRL, PORT | 32'd5);
    settle();
    check("R7 level 5 == thr 5", 64'(thr_irq_o), 0);
    man_rd("R13 manual head 0");
    man_rd("R13 manual head 1");
    settle();
    check("R13 level after reads", 64'(fifo_level_o), 3);

    // first DMA
    mem_rdy_i = 1'b1;
    exp_addr = 32'h100;
    wr(S_BASE, 32'h100);
    wr(S_CNT, 32'd6);
    e0 = eot_cnt;
    wr(S_CTRL, PORT | DMA | 32'd0);
    #1;
    check("R2 busy after start", 64'(dma_busy_o), 1);
    check("R8 thr quiet under DMA", 64'(thr_irq_o), 0);
    for (int i = 0; i < 3; i++) push(32'hB0 + i, 1);
    wait_idle();
    check("R4 busy cleared", 64'(dma_busy_o), 0);
    check("R4 all words moved", 64'(exp_q.size()), 0);
    check("R4 one eot pulse", 64'(eot_cnt - e0), 1);
    check("R4 eot status", 64'(eot_sts_o), 1);
    wr(S_STAT, 32'h1);
    settle();
    check("R12 eot cleared", 64'(eot_sts_o), 0);

    // pause and resume
    wr(S_CTRL, PORT);
    mem_rdy_i = 1'b0;
    exp_addr = 32'h200;
    wr(S_BASE, 32'h200);
    wr(S_CNT, 32'd5);
    e0 = eot_cnt;
    wr(S_CTRL, PORT | DMA);
    push(32'hC0, 1);
    push(32'hC1, 1);
    mem_rdy_i = 1'b1;
    settle(); settle();
    check("R3 two moved", 64'(exp_q.size()), 0);
    wr(S_CTRL, PORT | 32'd7);
    wr(S_BASE, 32'h999);
    wr(S_CNT, 32'd9);
    for (int i = 0; i < 3; i++) push(32'hD0 + i, 1);
    settle();
    check("R5 level held in pause", 64'(fifo_level_o), 3);
    check("R5 no request in pause", 64'(mem_req_o), 0);
    check("R6 still outstanding", 64'(dma_busy_o), 1);
    check("R9 threshold write ignored", 64'(thr_irq_o), 1);
    wr(S_CTRL, PORT | DMA);
    wait_idle();
    check("R6 resumed to completion", 64'(exp_q.size()), 0);
    check("R9 count write ignored", 64'(eot_cnt - e0), 1);
    check("R9 final addr", 64'(exp_addr), 64'h205);

    // abort by port disable
    wr(S_CTRL, PORT);
    mem_rdy_i = 1'b0;
    wr(S_BASE, 32'h300);
    wr(S_CNT, 32'd4);
    wr(S_CTRL, PORT | DMA);
    push(32'hE0, 1);
    push(32'hE1, 1);
    settle();
    check("R10 pre-abort level", 64'(fifo_level_o), 2);
    e0 = eot_cnt;
    wr(S_CTRL, 32'h0);
    exp_q.delete();
    settle();
    check("R10 flushed", 64'(fifo_level_o), 0);
    check("R10 aborted", 64'(dma_busy_o), 0);
    repeat (4) @(negedge clk_i);
    check("R10 no eot on abort", 64'(eot_cnt - e0), 0);
    wr(S_CTRL, PORT);
    exp_addr = 32'h400;
    wr(S_BASE, 32'h400);
    wr(S_CNT, 32'd2);
    wr(S_CTRL, PORT | DMA);
    mem_rdy_i = 1'b1;
    push(32'hF0, 1);
    push(32'hF1, 1);
    wait_idle();
    check("R10 fresh start done", 64'(exp_q.size()), 0);
    check("R10 fresh eot", 64'(eot_cnt - e0), 1);

    // overflow
    wr(S_CTRL, PORT);
    for (int i = 0; i < 10; i++) push(32'h50 + i, i < 8);
    settle();
    check("R11 level full", 64'(fifo_level_o), 8);
    check("R11 overflow sticky", 64'(ovf_sts_o), 1);
    for (int i = 0; i < 8; i++) man_rd("R11 stored word kept");
    wr(S_STAT, 32'h2);
    settle();
    check("R12 overflow cleared", 64'(ovf_sts_o), 0);
    wr(S_CTRL, 32'h0);
    push(32'h77, 0);
    wr(S_CTRL, PORT);
    settle();
    check("R11 disabled port ignores input", 64'(fifo_level_o), 0);

    // manual read ignored while DMA enabled
    wr(S_CNT, 32'd0);
    push(32'h61, 1);
    push(32'h62, 1);
    wr(S_CTRL, PORT | DMA);
    settle();
    check("R2 zero count no start", 64'(dma_busy_o), 0);
    check("R8 thr quiet with DMA on", 64'(thr_irq_o), 0);
    @(negedge clk_i); sw_rd_i = 1'b1;
    @(negedge clk_i); sw_rd_i = 1'b0;
    settle();
    check("R13 read ignored under DMA", 64'(fifo_level_o), 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule